// File: doc/BRIEF.md
# Step-of-Three Wrapping Counter

This block is a small up-counter that moves on the high-to-low transition of its clock input. Each enabled transition adds a fixed step to the count, three by default. The sum is truncated to the counter width, so a 3-bit counter goes through all eight codes in the order 0, 3, 6, 1, 4, 7, 2, 5 before it returns to 0.

A clear input, active high, is asynchronous. It forces the count to zero the moment it rises, needs no clock, and beats both the enable and any clock transition that arrives while it is asserted. An enable input, active high, decides whether a falling clock transition advances the count or leaves it unchanged.

The counter width and the step are parameters. The step is reduced modulo two to the power of the width when the design elaborates, so any step value gives well-defined wraparound. A reduced step of zero selects a variant in which the count never moves.

Top module: `step_wrap_counter`

## Requirements
- R1: The count changes only on a falling transition of `tick_i` (or through clear). A rising transition or a change of `enable_i` between transitions leaves `count_o` unchanged.
- R2: A rise of `clear_i` sets `count_o` to 0 at once, without any clock transition.
- R3: While `clear_i` is high, `count_o` stays 0 even when `enable_i` is high and falling transitions occur.
- R4: On a falling transition with `clear_i` low and `enable_i` high, `count_o` becomes (old + STEP) mod 2^WIDTH. With the defaults, 5 goes to 0, 6 goes to 1 and 7 goes to 2.
- R5: On a falling transition with `enable_i` low, `count_o` keeps its value.
- R6: After clear is released, the first enabled falling transition moves the count from 0 to the reduced step, which is 3 with the defaults.
- R7: With the defaults, eight enabled falling transitions after a clear visit each of the eight codes exactly once and leave the count at 0.
- R8: STEP is reduced modulo 2^WIDTH, so STEP=11 with WIDTH=3 behaves exactly like STEP=3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tick_i | input | 1 | Clock; the count advances on its falling transition |
| clear_i | input | 1 | Asynchronous clear, active high, with top priority |
| enable_i | input | 1 | Count enable, active high |
| count_o | output | WIDTH (3) | Present count value |

## Verification
The bench goes after the three wrap points (5, 6 and 7). An adder that kept a carry, or one that saturated, would produce 8, 9 or 10, or would stop at 7. Clear is asserted halfway through a count and sampled before the next falling transition, which catches a clear that only acts on a clock edge. Clear is also held across an enabled falling transition to show that it outranks enable. The bench changes the enable just after a rising transition and checks the count immediately, which exposes a design that counts on the wrong edge. A full eight-step walk records every code that appears, so a wrong step or a shortened cycle shows up as a missing state or a final value other than zero.

// File: rtl/swc_pkg.sv
`timescale 1ns/1ps
package swc_pkg;
   localparam int unsigned SWC_MAX_WIDTH = 16;

   function automatic int unsigned swc_reduce_step(input int unsigned step,
                                                   input int unsigned width);
      return step % (32'd1 << width);
   endfunction
endpackage

// File: rtl/swc_step_adder.sv
`timescale 1ns/1ps
module swc_step_adder #(
   parameter int unsigned WIDTH    = 3,
   parameter int unsigned STEP_MOD = 3
) (
   input  logic [WIDTH-1:0] cur_i,
   output logic [WIDTH-1:0] nxt_o
);
   generate
      if (STEP_MOD == 0) begin : g_hold
         assign nxt_o = cur_i;
      end else begin : g_add
         localparam logic [WIDTH-1:0] INC = WIDTH'(STEP_MOD);
         assign nxt_o = cur_i + INC;
      end
   endgenerate
endmodule

// File: rtl/swc_state_reg.sv
`timescale 1ns/1ps
module swc_state_reg #(
   parameter int unsigned WIDTH    = 3,
   parameter int unsigned STEP_MOD = 3
) (
   input  logic             tick_i,
   input  logic             clear_i,
   input  logic             enable_i,
   input  logic [WIDTH-1:0] nxt_i,
   output logic [WIDTH-1:0] count_o
);
   localparam logic [WIDTH-1:0] STEP_VEC = WIDTH'(STEP_MOD);

   logic [WIDTH-1:0] state_q;

   always_ff @(negedge tick_i or posedge clear_i) begin
      if (clear_i)       state_q <= '0;
      else if (enable_i) state_q <= nxt_i;
   end

   assign count_o = state_q;

   // Records whether clear was seen since the previous falling transition.
   logic clr_seen_q;
   always_ff @(negedge tick_i or posedge clear_i) begin
      if (clear_i) clr_seen_q <= 1'b1;
      else         clr_seen_q <= 1'b0;
   end

   // R3 / R2: a clear since the last transition leaves the count at zero
   assert_clear_zero_R3: assert property (@(negedge tick_i) disable iff (clear_i)
      clr_seen_q |-> count_o == '0);

   // R4: an enabled transition with no intervening clear adds the step
   assert_step_add_R4: assert property (@(negedge tick_i) disable iff (clear_i)
      ($past(enable_i) && !clr_seen_q && !$past(clr_seen_q))
         |-> count_o == WIDTH'($past(count_o) + STEP_VEC));

   // R5: a disabled transition holds the count
   assert_hold_R5: assert property (@(negedge tick_i) disable iff (clear_i)
      (!$past(enable_i) && !clr_seen_q && !$past(clr_seen_q)) |-> $stable(count_o));

   // R6: first enabled transition after a clear lands on the step value
   assert_first_step_R6: assert property (@(negedge tick_i) disable iff (clear_i)
      ($past(clr_seen_q) && $past(enable_i) && !$past(clear_i) && !clr_seen_q)
         |-> count_o == STEP_VEC);
endmodule

// File: rtl/step_wrap_counter.sv
`timescale 1ns/1ps
module step_wrap_counter #(
   parameter int unsigned WIDTH = 3,
   parameter int unsigned STEP  = 3
) (
   input  logic             tick_i,
   input  logic             clear_i,
   input  logic             enable_i,
   output logic [WIDTH-1:0] count_o
);
   import swc_pkg::*;

   localparam int unsigned STEP_MOD = swc_reduce_step(STEP, WIDTH);

   generate
      if (WIDTH < 1 || WIDTH > SWC_MAX_WIDTH) begin : g_bad_width
         $error("step_wrap_counter: WIDTH out of range");
      end
   endgenerate

   logic [WIDTH-1:0] nxt_w;
   logic [WIDTH-1:0] cur_w;

   swc_step_adder #(.WIDTH(WIDTH), .STEP_MOD(STEP_MOD)) u_adder (
      .cur_i (cur_w),
      .nxt_o (nxt_w)
   );

   swc_state_reg #(.WIDTH(WIDTH), .STEP_MOD(STEP_MOD)) u_state (
      .tick_i   (tick_i),
      .clear_i  (clear_i),
      .enable_i (enable_i),
      .nxt_i    (nxt_w),
      .count_o  (cur_w)
   );

   assign count_o = cur_w;
endmodule

// File: tb/step_wrap_counter_bench.sv
`timescale 1ns/1ps
module step_wrap_counter_bench;
   logic clk = 1'b0;
   logic clear = 1'b1;
   logic enable = 1'b0;
   logic [2:0] count;
   logic [2:0] count_alt;

   always #5 clk = ~clk;

   step_wrap_counter u_step_wrap_counter (
      .tick_i(clk), .clear_i(clear), .enable_i(enable), .count_o(count));

   // R8: a step of 11 on a 3-bit counter must act as a step of 3
   step_wrap_counter #(.WIDTH(3), .STEP(11)) u_alt (
      .tick_i(clk), .clear_i(clear), .enable_i(enable), .count_o(count_alt));

   int total = 0;
   int bad = 0;
   int unsigned model = 0;
   int unsigned exp_q[$];
   string tag_q[$];
   bit done = 0;

   task automatic check(input bit ok, input string tag,
                        input int unsigned act, input int unsigned exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s: got %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic drive(input logic e, input logic c, input string tag);
      @(posedge clk);
      #1;
      enable = e;
      clear = c;
      if (c) model = 0;
      else if (e) model = (model + 3) % 8;
      exp_q.push_back(model);
      tag_q.push_back(tag);
   endtask

   // monitor: compares after every falling transition
   initial begin
      forever begin
         @(negedge clk);
         #2;
         while (exp_q.size() > 0) begin
            automatic int unsigned e = exp_q.pop_front();
            automatic string t = tag_q.pop_front();
            check(count == 3'(e), t, count, e);
            check(count_alt == count, "R8", count_alt, count);
         end
      end
   end

   initial begin
      #(200000 * 10);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #2;
      check(count == 3'd0, "R2 reset", count, 0);

      drive(1'b0, 1'b0, "R5 idle after release");
      drive(1'b0, 1'b0, "R5 hold zero");
      drive(1'b1, 1'b0, "R6 first step");
      drive(1'b1, 1'b0, "R4 3->6");

      // R1: enable changed after a rising transition does not move the count
      @(posedge clk);
      #1;
      enable = 1'b1;
      #3;
      check(count == 3'd6, "R1 no change before falling edge", count, 6);
      exp_q.push_back((model + 3) % 8);
      tag_q.push_back("R4 6->1");
      model = (model + 3) % 8;

      drive(1'b0, 1'b0, "R5 hold at 1");
      drive(1'b1, 1'b0, "R4 1->4");

      // R2: asynchronous clear in the middle of a count
      @(posedge clk);
      #1;
      clear = 1'b1;
      #1;
      check(count == 3'd0, "R2 async clear", count, 0);
      model = 0;
      exp_q.push_back(0);
      tag_q.push_back("R3 clear beats enable");

      drive(1'b1, 1'b1, "R3 clear held");
      drive(1'b1, 1'b1, "R3 clear held again");

      // R7: eight-step walk from zero
      begin
         automatic logic [7:0] seen = 8'h00;
         for (int i = 0; i < 8; i++) begin
            drive(1'b1, 1'b0, "R4 walk");
            @(negedge clk);
            #3;
            seen[count] = 1'b1;
         end
         check(seen == 8'hFF, "R7 all codes visited", seen, 8'hFF);
         check(count == 3'd0, "R7 back to zero", count, 0);
      end

      drive(1'b0, 1'b0, "R5 final hold");
      @(posedge clk);
      #1;
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule